// File: doc/BRIEF.md
# eBPF Instruction Field Decoder

This block is a purely combinational field decoder for eBPF instruction words. A fetch stage presents the first 64-bit instruction word and, alongside it, the 64-bit word that follows in memory. The decoder splits the opcode byte both ways at once: as an operation, source-select and class triple, and as a mode, size and class triple. It picks the destination and source register indices from the register byte, and it produces the 16-bit offset and 32-bit immediate, each also sign-extended to 64 bits.

Both words arrive already assembled, so no byte-order conversion of fetched bytes is done here. One input selects which nibble of the register byte holds the destination register. For the single two-word form, the wide immediate load, the decoder builds the 64-bit immediate from both words. It tells the fetch logic to step 16 bytes instead of 8. An illegal flag marks reserved load/store modes, undefined ALU operations and a wide load whose second word has a non-zero pad.

Top module: `bpf_insn_decoder`

## Requirements
- R1: Inside each assembled 64-bit word the opcode byte is bits [7:0], the register byte bits [15:8], the 16-bit offset bits [31:16] and the 32-bit immediate bits [63:32]. `off16` and `imm32` carry those fields of the first word unchanged.
- R2: With `regs_swapped` = 0 the destination index is bits [11:8] and the source index bits [15:12]. With `regs_swapped` = 1 the destination index is bits [15:12] and the source index bits [11:8].
- R3: `alu_op` is opcode bits [7:4], `use_reg` is bit [3] (0 = immediate operand, 1 = register operand) and `insn_class` is bits [2:0]. `ls_mode` is bits [7:5] and `ls_size` bits [4:3]. All of these are driven for every opcode.
- R4: `off_sx` is `off16` sign-extended to 64 bits, and `imm_sx` is `imm32` sign-extended to 64 bits.
- R5: `two_word` is 1 exactly when the class is 000 (plain load), the size is 11 (8 bytes) and the mode is 000 (immediate), which is opcode 0x18.
- R6: When `two_word` is 1, `imm64` equals the second word's bits [63:32] above the first word's bits [63:32]. Otherwise `imm64` equals `imm_sx`.
- R7: For load/store classes 000 to 011, the modes 100, 101 and 111 set `illegal`. The modes 000, 001, 010, 011 and 110 (atomic add) do not.
- R8: For classes 100 (32-bit ALU) and 111 (64-bit ALU), an operation code of 0xE or 0xF sets `illegal`. For the jump classes 101 and 110 those codes do not.
- R9: When `two_word` is 1 and the second word's bits [31:0] are not zero, `illegal` is set. When `two_word` is 0 the second word affects no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| word0 | input | 64 | First instruction word, already assembled |
| word1 | input | 64 | Following word, used only by the wide immediate load |
| regs_swapped | input | 1 | Register-nibble layout: 0 = destination in low nibble, 1 = destination in high nibble |
| insn_class | output | 3 | Instruction class, opcode bits [2:0] |
| alu_op | output | 4 | ALU / jump operation code |
| use_reg | output | 1 | Source select: 1 = register operand, 0 = immediate |
| ls_mode | output | 3 | Load/store addressing mode |
| ls_size | output | 2 | Load/store access size |
| dst_idx | output | 4 | Destination register index |
| src_idx | output | 4 | Source register index |
| off16 | output | 16 | Raw signed offset field |
| off_sx | output | 64 | Offset sign-extended to 64 bits |
| imm32 | output | 32 | Raw signed immediate field |
| imm_sx | output | 64 | Immediate sign-extended to 64 bits |
| imm64 | output | 64 | Assembled 64-bit immediate |
| two_word | output | 1 | Instruction occupies two words; advance fetch by 16 bytes |
| illegal | output | 1 | Encoding is reserved or malformed |

## Verification
The block holds no state, so any fault shows on the outputs in the same evaluation as the input that exposes it. Nothing is hidden for later. A swapped nibble select shows as exchanged register indices under one layout only. A wrong sign-extension shows only when the top bit of the offset or immediate is set. The bench therefore drives values with those top bits both set and clear. A misdecoded wide load shows as a wrong fetch step (`two_word`), a wrong upper half of `imm64`, or a missing `illegal` when the second word's pad bits are non-zero. Opcodes next to 0x18 are driven to make sure `two_word` stays low for them.

// File: rtl/bpf_dec_pkg.sv
// Package: shared widths and encodings for the eBPF field decoder.
// Assumes 64-bit instruction words assembled with the opcode in the low byte.
package bpf_dec_pkg;

    localparam int WORD_W = 64;
    localparam int OPC_W  = 8;
    localparam int REGB_W = 8;
    localparam int NIB_W  = 4;
    localparam int OFF_W  = 16;
    localparam int IMM_W  = 32;
    localparam int CLS_W  = 3;
    localparam int OP_W   = 4;
    localparam int MODE_W = 3;
    localparam int SIZE_W = 2;

    localparam int REGB_LSB = OPC_W;
    localparam int OFF_LSB  = REGB_LSB + REGB_W;
    localparam int IMM_LSB  = OFF_LSB + OFF_W;

    typedef enum logic [CLS_W-1:0] {
        CLS_LOAD    = 3'b000,
        CLS_LOADX   = 3'b001,
        CLS_STORE   = 3'b010,
        CLS_STOREX  = 3'b011,
        CLS_ARITH32 = 3'b100,
        CLS_BRANCH  = 3'b101,
        CLS_BRANCH32= 3'b110,
        CLS_ARITH64 = 3'b111
    } insn_class_e;

    typedef enum logic [MODE_W-1:0] {
        AM_IMMED   = 3'b000,
        AM_ABSOL   = 3'b001,
        AM_INDIR   = 3'b010,
        AM_MEMORY  = 3'b011,
        AM_RSV4    = 3'b100,
        AM_RSV5    = 3'b101,
        AM_ATOMADD = 3'b110,
        AM_RSV7    = 3'b111
    } ls_mode_e;

    typedef enum logic [SIZE_W-1:0] {
        SZ_4B = 2'b00,
        SZ_2B = 2'b01,
        SZ_1B = 2'b10,
        SZ_8B = 2'b11
    } ls_size_e;

    localparam logic [OP_W-1:0] ARITH_OP_MAX = 4'hD;

endpackage

// File: rtl/bpf_opcode_split.sv
// Opcode splitter: views the opcode byte both as op/src/class and as
// mode/size/class, and recognises the two-word immediate load.
// Assumes the opcode byte layout given in the package widths.
module bpf_opcode_split
    import bpf_dec_pkg::*;
#(
    parameter int P_OPC_W = OPC_W
) (
    input  logic [P_OPC_W-1:0] opcode,
    output logic [CLS_W-1:0]   cls,
    output logic [OP_W-1:0]    op,
    output logic               src_sel,
    output logic [MODE_W-1:0]  mode,
    output logic [SIZE_W-1:0]  size,
    output logic               wide_load
);

    localparam int MODE_LSB = P_OPC_W - MODE_W;
    localparam int SIZE_LSB = CLS_W;
    localparam int OP_LSB   = P_OPC_W - OP_W;

    // Slice the opcode into both interpretations.
    always_comb begin
        cls     = opcode[CLS_W-1:0];
        src_sel = opcode[CLS_W];
        op      = opcode[P_OPC_W-1:OP_LSB];
        mode    = opcode[P_OPC_W-1:MODE_LSB];
        size    = opcode[SIZE_LSB+SIZE_W-1:SIZE_LSB];
    end

    // Detect the 64-bit immediate load that spans two words.
    always_comb begin
        wide_load = (insn_class_e'(cls) == CLS_LOAD) &&
                    (ls_size_e'(size)   == SZ_8B)    &&
                    (ls_mode_e'(mode)   == AM_IMMED);
    end

endmodule

// File: rtl/bpf_reg_select.sv
// Register-index selector: picks destination and source nibbles from the
// register byte according to the layout select input.
// Assumes the register byte holds exactly two nibble-wide indices.
module bpf_reg_select
    import bpf_dec_pkg::*;
#(
    parameter int P_NIB_W = NIB_W
) (
    input  logic [2*P_NIB_W-1:0] reg_byte,
    input  logic                 swap,
    output logic [P_NIB_W-1:0]   dst,
    output logic [P_NIB_W-1:0]   src
);

    logic [P_NIB_W-1:0] nib [2];

    // Split the register byte into its low and high nibbles.
    for (genvar g = 0; g < 2; g++) begin : g_nib
        assign nib[g] = reg_byte[g*P_NIB_W +: P_NIB_W];
    end

    // Route the nibbles to destination and source by layout.
    always_comb begin
        if (swap) begin
            dst = nib[1];
            src = nib[0];
        end else begin
            dst = nib[0];
            src = nib[1];
        end
    end

endmodule

// File: rtl/bpf_imm_build.sv
// Immediate builder: sign-extends offset and immediate, and assembles the
// 64-bit immediate from two words for the wide load.
// Assumes the output word is exactly twice the immediate width.
module bpf_imm_build
    import bpf_dec_pkg::*;
#(
    parameter int P_OFF_W  = OFF_W,
    parameter int P_IMM_W  = IMM_W,
    parameter int P_WORD_W = WORD_W
) (
    input  logic [P_OFF_W-1:0]  off_raw,
    input  logic [P_IMM_W-1:0]  imm_lo,
    input  logic [P_IMM_W-1:0]  imm_hi,
    input  logic                wide,
    output logic [P_WORD_W-1:0] off_ext,
    output logic [P_WORD_W-1:0] imm_ext,
    output logic [P_WORD_W-1:0] imm_full
);

    localparam int OFF_PAD = P_WORD_W - P_OFF_W;
    localparam int IMM_PAD = P_WORD_W - P_IMM_W;

    // Replicate the sign bits into the upper parts.
    always_comb begin
        off_ext = {{OFF_PAD{off_raw[P_OFF_W-1]}}, off_raw};
        imm_ext = {{IMM_PAD{imm_lo[P_IMM_W-1]}}, imm_lo};
    end

    // Choose the assembled two-word value or the extended single immediate.
    always_comb begin
        if (wide) begin
            imm_full = {imm_hi, imm_lo};
        end else begin
            imm_full = imm_ext;
        end
    end

endmodule

// File: rtl/bpf_legal_check.sv
// Legality checker: flags reserved load/store modes, undefined arithmetic
// operations and a non-zero pad in the second word of a wide load.
// Assumes class and field values come from the opcode splitter.
module bpf_legal_check
    import bpf_dec_pkg::*;
#(
    parameter int P_PAD_W = IMM_W
) (
    input  logic [CLS_W-1:0]   cls,
    input  logic [OP_W-1:0]    op,
    input  logic [MODE_W-1:0]  mode,
    input  logic               wide,
    input  logic [P_PAD_W-1:0] pad,
    output logic               bad
);

    logic is_ls;
    logic is_arith;
    logic mode_bad;
    logic op_bad;
    logic pad_bad;

    // Classify the instruction family.
    always_comb begin
        is_ls    = (cls[CLS_W-1] == 1'b0);
        is_arith = (insn_class_e'(cls) == CLS_ARITH32) ||
                   (insn_class_e'(cls) == CLS_ARITH64);
    end

    // Flag modes that carry no defined meaning.
    always_comb begin
        unique case (ls_mode_e'(mode))
            AM_RSV4, AM_RSV5, AM_RSV7: mode_bad = is_ls;
            default:                   mode_bad = 1'b0;
        endcase
    end

    // Flag arithmetic codes above the last defined operation.
    always_comb begin
        op_bad = is_arith && (op > ARITH_OP_MAX);
    end

    // Flag a wide load whose second-word pad is not zero.
    always_comb begin
        pad_bad = wide && (|pad);
    end

    // Combine all illegal conditions.
    always_comb begin
        bad = mode_bad | op_bad | pad_bad;
    end

endmodule

// File: rtl/bpf_insn_decoder.sv
// Top of the eBPF instruction field decoder. Purely combinational: slices
// the first word, selects register nibbles, builds immediates and checks
// legality. Assumes both words are already assembled to host order.
module bpf_insn_decoder
    import bpf_dec_pkg::*;
(
    input  logic [63:0] word0,
    input  logic [63:0] word1,
    input  logic        regs_swapped,
    output logic [2:0]  insn_class,
    output logic [3:0]  alu_op,
    output logic        use_reg,
    output logic [2:0]  ls_mode,
    output logic [1:0]  ls_size,
    output logic [3:0]  dst_idx,
    output logic [3:0]  src_idx,
    output logic [15:0] off16,
    output logic [63:0] off_sx,
    output logic [31:0] imm32,
    output logic [63:0] imm_sx,
    output logic [63:0] imm64,
    output logic        two_word,
    output logic        illegal
);

    logic [OPC_W-1:0]  opc;
    logic [REGB_W-1:0] regb;
    logic [IMM_W-1:0]  hi_imm;
    logic [IMM_W-1:0]  hi_pad;

    // Extract the raw fields from the two words.
    always_comb begin
        opc    = word0[OPC_W-1:0];
        regb   = word0[REGB_LSB +: REGB_W];
        off16  = word0[OFF_LSB +: OFF_W];
        imm32  = word0[IMM_LSB +: IMM_W];
        hi_imm = word1[IMM_LSB +: IMM_W];
        hi_pad = word1[IMM_W-1:0];
    end

    bpf_opcode_split #(.P_OPC_W(OPC_W)) u_split (
        .opcode    (opc),
        .cls       (insn_class),
        .op        (alu_op),
        .src_sel   (use_reg),
        .mode      (ls_mode),
        .size      (ls_size),
        .wide_load (two_word)
    );

    bpf_reg_select #(.P_NIB_W(NIB_W)) u_regs (
        .reg_byte (regb),
        .swap     (regs_swapped),
        .dst      (dst_idx),
        .src      (src_idx)
    );

    bpf_imm_build #(
        .P_OFF_W  (OFF_W),
        .P_IMM_W  (IMM_W),
        .P_WORD_W (WORD_W)
    ) u_imm (
        .off_raw  (off16),
        .imm_lo   (imm32),
        .imm_hi   (hi_imm),
        .wide     (two_word),
        .off_ext  (off_sx),
        .imm_ext  (imm_sx),
        .imm_full (imm64)
    );

    bpf_legal_check #(.P_PAD_W(IMM_W)) u_legal (
        .cls  (insn_class),
        .op   (alu_op),
        .mode (ls_mode),
        .wide (two_word),
        .pad  (hi_pad),
        .bad  (illegal)
    );

endmodule

// File: rtl/bpf_insn_decoder_chk.sv
// Checker for the decoder: immediate assertions evaluated whenever the
// ports change, since the block holds no clocked state.
module bpf_insn_decoder_chk (
    input logic [63:0] word0,
    input logic [63:0] word1,
    input logic        regs_swapped,
    input logic [2:0]  insn_class,
    input logic [2:0]  ls_mode,
    input logic [1:0]  ls_size,
    input logic [3:0]  dst_idx,
    input logic [3:0]  src_idx,
    input logic [15:0] off16,
    input logic [63:0] off_sx,
    input logic [31:0] imm32,
    input logic [63:0] imm_sx,
    input logic [63:0] imm64,
    input logic        two_word,
    input logic        illegal
);

    logic known;

    // Skip checks until every input is driven.
    always_comb begin
        known = !$isunknown({word0, word1, regs_swapped});
    end

    // Cross-check outputs of separate sub-blocks against each other.
    always_comb begin
        if (known) begin
            AST_REG_PAIR: assert ((dst_idx ^ src_idx) == (word0[15:12] ^ word0[11:8])); // R2
            AST_OFF_EXT: assert (off_sx[15:0] == off16 && (&off_sx[63:15] || ~|off_sx[63:15])); // R4
            AST_IMM_EXT: assert (imm_sx[31:0] == imm32 && (&imm_sx[63:31] || ~|imm_sx[63:31])); // R4
            AST_WIDE_ONLY_DWIMM: assert (!two_word || (insn_class == 3'b000 && ls_size == 2'b11 && ls_mode == 3'b000)); // R5
            AST_IMM64_LOW: assert (imm64[31:0] == imm32); // R6
            AST_RSV_MODE: assert (!(insn_class[2] == 1'b0 && (ls_mode == 3'b100 || ls_mode == 3'b101)) || illegal); // R7
            AST_PAD_NONZERO: assert (!(two_word && word1[31:0] != 32'd0) || illegal); // R9
        end
    end

endmodule

bind bpf_insn_decoder bpf_insn_decoder_chk i_chk (
    .word0        (word0),
    .word1        (word1),
    .regs_swapped (regs_swapped),
    .insn_class   (insn_class),
    .ls_mode      (ls_mode),
    .ls_size      (ls_size),
    .dst_idx      (dst_idx),
    .src_idx      (src_idx),
    .off16        (off16),
    .off_sx       (off_sx),
    .imm32        (imm32),
    .imm_sx       (imm_sx),
    .imm64        (imm64),
    .two_word     (two_word),
    .illegal      (illegal)
);

// File: tb/test_bpf_insn_decoder.sv
module test_bpf_insn_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] word0 = '0;
    logic [63:0] word1 = '0;
    logic        regs_swapped = 1'b0;
    logic [2:0]  insn_class;
    logic [3:0]  alu_op;
    logic        use_reg;
    logic [2:0]  ls_mode;
    logic [1:0]  ls_size;
    logic [3:0]  dst_idx;
    logic [3:0]  src_idx;
    logic [15:0] off16;
    logic [63:0] off_sx;
    logic [31:0] imm32;
    logic [63:0] imm_sx;
    logic [63:0] imm64;
    logic        two_word;
    logic        illegal;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    bpf_insn_decoder i_bpf_insn_decoder (
        .word0(word0), .word1(word1), .regs_swapped(regs_swapped),
        .insn_class(insn_class), .alu_op(alu_op), .use_reg(use_reg),
        .ls_mode(ls_mode), .ls_size(ls_size), .dst_idx(dst_idx),
        .src_idx(src_idx), .off16(off16), .off_sx(off_sx), .imm32(imm32),
        .imm_sx(imm_sx), .imm64(imm64), .two_word(two_word), .illegal(illegal)
    );

    function automatic logic [63:0] mk(input logic [7:0] op, input logic [7:0] rb,
                                       input logic [15:0] off, input logic [31:0] imm);
        return {imm, off, rb, op};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Apply inputs at a falling edge and let the logic settle.
    task automatic apply(input logic [63:0] w0, input logic [63:0] w1, input logic sw);
        @(negedge clk);
        word0 = w0;
        word1 = w1;
        regs_swapped = sw;
        #1;
    endtask

    task automatic t_idle;
        apply('0, '0, 1'b0);
        chk("R5 idle two_word", 64'(two_word), 64'd0);
        chk("R7 idle illegal", 64'(illegal), 64'd0);
        chk("R6 idle imm64", imm64, 64'd0);
    endtask

    task automatic t_fields;
        apply(mk(8'hBF, 8'h00, 16'h1234, 32'hCAFEF00D), '0, 1'b0);
        chk("R1 off16", 64'(off16), 64'h1234);
        chk("R1 imm32", 64'(imm32), 64'hCAFEF00D);
        chk("R3 alu_op", 64'(alu_op), 64'hB);
        chk("R3 use_reg", 64'(use_reg), 64'd1);
        chk("R3 insn_class", 64'(insn_class), 64'd7);
        chk("R3 ls_mode", 64'(ls_mode), 64'd5);
        chk("R3 ls_size", 64'(ls_size), 64'd3);
        chk("R8 mov64 legal", 64'(illegal), 64'd0);
    endtask

    task automatic t_regs;
        apply(mk(8'h07, 8'h3A, 16'h0, 32'h0), '0, 1'b0);
        chk("R2 le dst", 64'(dst_idx), 64'hA);
        chk("R2 le src", 64'(src_idx), 64'h3);
        apply(mk(8'h07, 8'h3A, 16'h0, 32'h0), '0, 1'b1);
        chk("R2 be dst", 64'(dst_idx), 64'h3);
        chk("R2 be src", 64'(src_idx), 64'hA);
    endtask

    task automatic t_sext;
        apply(mk(8'h61, 8'h00, 16'h8001, 32'h80000000), '0, 1'b0);
        chk("R4 off neg", off_sx, 64'hFFFFFFFFFFFF8001);
        chk("R4 imm neg", imm_sx, 64'hFFFFFFFF80000000);
        chk("R6 single imm64", imm64, 64'hFFFFFFFF80000000);
        apply(mk(8'h61, 8'h00, 16'h7FFF, 32'h7FFFFFFF), '0, 1'b0);
        chk("R4 off pos", off_sx, 64'h0000000000007FFF);
        chk("R4 imm pos", imm_sx, 64'h000000007FFFFFFF);
    endtask

    task automatic t_wide;
        apply(mk(8'h18, 8'h05, 16'h0, 32'h89ABCDEF), {32'h01234567, 32'h0}, 1'b0);
        chk("R5 wide two_word", 64'(two_word), 64'd1);
        chk("R6 wide imm64", imm64, 64'h0123456789ABCDEF);
        chk("R9 wide clean legal", 64'(illegal), 64'd0);
        apply(mk(8'h10, 8'h05, 16'h0, 32'h89ABCDEF), {32'h01234567, 32'h0}, 1'b0);
        chk("R5 byte-size not wide", 64'(two_word), 64'd0);
        chk("R6 not wide imm64", imm64, 64'hFFFFFFFF89ABCDEF);
        apply(mk(8'h1B, 8'h00, 16'h0, 32'h0), '0, 1'b0);
        chk("R5 class3 not wide", 64'(two_word), 64'd0);
        apply(mk(8'h38, 8'h00, 16'h0, 32'h0), '0, 1'b0);
        chk("R5 mode1 not wide", 64'(two_word), 64'd0);
    endtask

    task automatic t_pad;
        apply(mk(8'h18, 8'h00, 16'h0, 32'h1), {32'h2, 32'h1}, 1'b0);
        chk("R9 pad nonzero illegal", 64'(illegal), 64'd1);
        apply(mk(8'h18, 8'h00, 16'h0, 32'h1), {32'h2, 32'h80000000}, 1'b0);
        chk("R9 pad top bit illegal", 64'(illegal), 64'd1);
        apply(mk(8'h61, 8'h00, 16'h0, 32'h5), 64'hFFFFFFFFFFFFFFFF, 1'b0);
        chk("R9 word1 ignored illegal", 64'(illegal), 64'd0);
        chk("R9 word1 ignored imm64", imm64, 64'd5);
    endtask

    task automatic t_modes;
        apply(mk(8'h81, 8'h00, 16'h0, 32'h0), '0, 1'b0);
        chk("R7 mode4 illegal", 64'(illegal), 64'd1);
        apply(mk(8'hA1, 8'h00, 16'h0, 32'h0), '0, 1'b0);
        chk("R7 mode5 illegal", 64'(illegal), 64'd1);
        apply(mk(8'hE3, 8'h00, 16'h0, 32'h0), '0, 1'b0);
        chk("R7 mode7 illegal", 64'(illegal), 64'd1);
        apply(mk(8'hC3, 8'h00, 16'h0, 32'h0), '0, 1'b0);
        chk("R7 atomic w legal", 64'(illegal), 64'd0);
        apply(mk(8'hDB, 8'h00, 16'h0, 32'h0), '0, 1'b0);
        chk("R7 atomic dw legal", 64'(illegal), 64'd0);
        apply(mk(8'h62, 8'h00, 16'h0, 32'h0), '0, 1'b0);
        chk("R7 mem store legal", 64'(illegal), 64'd0);
    endtask

    task automatic t_ops;
        apply(mk(8'hE4, 8'h00, 16'h0, 32'h0), '0, 1'b0);
        chk("R8 alu32 op E illegal", 64'(illegal), 64'd1);
        apply(mk(8'hFF, 8'h00, 16'h0, 32'h0), '0, 1'b0);
        chk("R8 alu64 op F illegal", 64'(illegal), 64'd1);
        apply(mk(8'hD4, 8'h00, 16'h0, 32'h0), '0, 1'b0);
        chk("R8 alu op D legal", 64'(illegal), 64'd0);
        apply(mk(8'hE5, 8'h00, 16'h0, 32'h0), '0, 1'b0);
        chk("R8 jmp op E legal", 64'(illegal), 64'd0);
        apply(mk(8'hFE, 8'h00, 16'h0, 32'h0), '0, 1'b0);
        chk("R8 jmp32 op F legal", 64'(illegal), 64'd0);
    endtask

    initial begin
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        t_idle();
        t_fields();
        t_regs();
        t_sext();
        t_wide();
        t_pad();
        t_modes();
        t_ops();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule